// File: doc/BRIEF.md
# Indirect Register Access Port

This block lets a host reach three banks of internal 8-bit registers (a mixer bank, a gain-control bank and a voice-detection bank) through a narrow window of six directly addressed bytes. Each bank is reached through two windows of its own: a control byte and a data byte. The control byte carries an index into the bank and a load bit. The data byte is a staging register on the write path and a view of the selected internal register on the read path.

To store a value, the host puts the byte into the data window, writes the index into the control window with the load bit low, writes the same index with the load bit high, and then clears the load bit again. The internal register is written exactly once, when the load bit goes from low to high. To fetch a value, the host writes the index with the load bit low and reads the data window. Read-modify-write of an internal register is these two sequences run one after the other. What the internal registers mean is outside this block.

Top module: `indirect_reg_port`

## Requirements
- R1: After reset every control byte, staging byte and internal register is zero, so every window reads 0x00.
- R2: Bank b has its control window at host offset 2*b and its data window at 2*b+1 (b = 0, 1, 2). Offsets 6 and 7 read 0x00, and writes to them change nothing.
- R3: The control byte holds the index in bits 4:0 and the load bit in bit 7. Bits 6:5 always read 0, whatever was written to them.
- R4: A write to a data window stores the byte in that bank's staging register and does not change any internal register.
- R5: A control write that takes the load bit from 0 to 1 copies the staging byte into the internal register named by the index in that same write. The value can be read back from the next cycle on.
- R6: A control write that leaves the load bit at 1, or takes it from 1 to 0, commits nothing. This holds even when the index changes.
- R7: Reading a data window returns the internal register named by the current index while the load bit is 0. It returns the staging byte while the load bit is 1.
- R8: Each bank holds 16 internal registers. Indexes 16 to 31 read 0x00 through the data window, and a commit to them changes nothing.
- R9: The banks are independent: writing to the windows of one bank never changes the state of another bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Host write strobe for one cycle |
| bus_addr | input | 3 | Host window offset |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data for the window at bus_addr (combinational) |

## Verification
A wrong internal register or staging byte stays hidden until the host selects it. It then shows on bus_rdata in the same cycle as the data-window read. A false or missed commit therefore shows up only at the next readback of that index. For this reason the bench reads back every index of every bank after the fill and the corner sequences. A wrong control byte shows at once on a control-window read, and also as the wrong register on the next data-window read.

// File: rtl/ipa_pkg.sv
package ipa_pkg;

   typedef enum logic {
      WIN_CTRL = 1'b0,
      WIN_DATA = 1'b1
   } win_kind_e;

   // host offset of one window of one bank
   function automatic int win_offset(input int bank, input win_kind_e kind);
      return 2 * bank + ((kind == WIN_DATA) ? 1 : 0);
   endfunction

endpackage

// File: rtl/ipa_decode.sv
module ipa_decode
   import ipa_pkg::*;
#(
   parameter int NUM_BANKS = 3,
   parameter int HOST_AW   = 3
) (
   input  logic                 bus_wr,
   input  logic [HOST_AW-1:0]   bus_addr,
   output logic [NUM_BANKS-1:0] ctrl_wr,
   output logic [NUM_BANKS-1:0] data_wr
);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam logic [HOST_AW-1:0] CtrlOff = HOST_AW'(win_offset(b, WIN_CTRL));
      localparam logic [HOST_AW-1:0] DataOff = HOST_AW'(win_offset(b, WIN_DATA));
      assign ctrl_wr[b] = bus_wr && (bus_addr == CtrlOff);
      assign data_wr[b] = bus_wr && (bus_addr == DataOff);
   end

endmodule

// File: rtl/ipa_bank.sv
module ipa_bank #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 5,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ctrl_rd,
   output logic [DATA_W-1:0] data_rd,
   output logic              commit
);

   localparam int LOAD_BIT = DATA_W - 1;
   localparam int SLOT_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [IDX_W:0] DEPTH_L = (IDX_W + 1)'(DEPTH);

   logic [IDX_W-1:0]             idx_q;
   logic                         load_q;
   logic [DATA_W-1:0]            stage_q;
   logic [DEPTH-1:0][DATA_W-1:0] arr_q;

   logic [IDX_W-1:0] new_idx;
   logic             new_in_range;
   logic             cur_in_range;
   logic [DATA_W-1:0] sel_word;

   assign new_idx      = wdata[IDX_W-1:0];
   assign new_in_range = {1'b0, new_idx} < DEPTH_L;
   assign cur_in_range = {1'b0, idx_q} < DEPTH_L;

   // a commit is the rising edge of the load bit caused by a control write
   assign commit = ctrl_wr && !load_q && wdata[LOAD_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         load_q <= 1'b0;
      end else if (ctrl_wr) begin
         idx_q  <= new_idx;
         load_q <= wdata[LOAD_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else if (data_wr) begin
         stage_q <= wdata;
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_reg
      localparam logic [IDX_W-1:0] MyIdx = IDX_W'(i);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            arr_q[i] <= '0;
         end else if (commit && new_in_range && (new_idx == MyIdx)) begin
            arr_q[i] <= stage_q;
         end
      end
   end

   always_comb begin
      sel_word = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (idx_q == IDX_W'(i)) sel_word = arr_q[i];
      end
   end

   always_comb begin
      ctrl_rd                = '0;
      ctrl_rd[LOAD_BIT]      = load_q;
      ctrl_rd[IDX_W-1:0]     = idx_q;
   end

   assign data_rd = load_q ? stage_q : (cur_in_range ? sel_word : '0);

   AST_COMMIT_STORES: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && new_in_range) |=> arr_q[$past(new_idx[SLOT_W-1:0])] == $past(stage_q)); // R5
   AST_NO_COMMIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> arr_q == $past(arr_q)); // R6
   AST_STAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !data_wr |=> $stable(stage_q)); // R4
   AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !new_in_range) |=> $stable(arr_q)); // R8
   AST_LOAD_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> load_q && !$past(load_q)); // R6

endmodule

// File: rtl/ipa_rdmux.sv
module ipa_rdmux
   import ipa_pkg::*;
#(
   parameter int NUM_BANKS = 3,
   parameter int HOST_AW   = 3,
   parameter int DATA_W    = 8
) (
   input  logic [HOST_AW-1:0]                  bus_addr,
   input  logic [NUM_BANKS-1:0][DATA_W-1:0]    ctrl_rd,
   input  logic [NUM_BANKS-1:0][DATA_W-1:0]    data_rd,
   output logic [DATA_W-1:0]                   bus_rdata
);

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bus_addr == HOST_AW'(win_offset(b, WIN_CTRL))) bus_rdata = ctrl_rd[b];
         if (bus_addr == HOST_AW'(win_offset(b, WIN_DATA))) bus_rdata = data_rd[b];
      end
   end

endmodule

// File: rtl/indirect_reg_port.sv
module indirect_reg_port #(
   parameter int NUM_BANKS = 3,
   parameter int DEPTH     = 16,
   parameter int DATA_W    = 8,
   parameter int IDX_W     = 5,
   parameter int HOST_AW   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [HOST_AW-1:0] bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata
);

   // elaboration-time parameter checks
   if (IDX_W >= DATA_W) begin : g_bad_idx
      $error("index field must leave room for the load bit");
   end
   if ((1 << IDX_W) < DEPTH) begin : g_bad_depth
      $error("index field too narrow for bank depth");
   end
   if (2 * NUM_BANKS > (1 << HOST_AW)) begin : g_bad_map
      $error("host window too small for all banks");
   end

   logic [NUM_BANKS-1:0]             ctrl_wr;
   logic [NUM_BANKS-1:0]             data_wr;
   logic [NUM_BANKS-1:0]             commit;
   logic [NUM_BANKS-1:0][DATA_W-1:0] ctrl_rd;
   logic [NUM_BANKS-1:0][DATA_W-1:0] data_rd;

   ipa_decode #(
      .NUM_BANKS (NUM_BANKS),
      .HOST_AW   (HOST_AW)
   ) u_decode (
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .ctrl_wr  (ctrl_wr),
      .data_wr  (data_wr)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      ipa_bank #(
         .DATA_W (DATA_W),
         .IDX_W  (IDX_W),
         .DEPTH  (DEPTH)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .ctrl_wr (ctrl_wr[b]),
         .data_wr (data_wr[b]),
         .wdata   (bus_wdata),
         .ctrl_rd (ctrl_rd[b]),
         .data_rd (data_rd[b]),
         .commit  (commit[b])
      );
   end

   ipa_rdmux #(
      .NUM_BANKS (NUM_BANKS),
      .HOST_AW   (HOST_AW),
      .DATA_W    (DATA_W)
   ) u_rdmux (
      .bus_addr  (bus_addr),
      .ctrl_rd   (ctrl_rd),
      .data_rd   (data_rd),
      .bus_rdata (bus_rdata)
   );

   AST_ONE_BANK_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(commit)); // R9
   AST_WRITE_TARGETS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({ctrl_wr, data_wr}) <= 1); // R2

endmodule

// File: tb/indirect_reg_port_bench.sv
module indirect_reg_port_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   // behavioural reference state
   int m_idx[3];
   int m_load[3];
   int m_stage[3];
   int m_mem[3][32];

   always #10 clk = ~clk;

   indirect_reg_port u_indirect_reg_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata)
   );

   function automatic int model_rd(input int a);
      int b;
      if (a >= 6) return 0;
      b = a / 2;
      if (a % 2 == 0) return (m_load[b] * 128) + m_idx[b];
      if (m_load[b] != 0) return m_stage[b];
      if (m_idx[b] < 16) return m_mem[b][m_idx[b]];
      return 0;
   endfunction

   function automatic void model_wr(input int a, input int d);
      int b;
      if (a >= 6) return;
      b = a / 2;
      if (a % 2 == 1) begin
         m_stage[b] = d;
      end else begin
         if (m_load[b] == 0 && (d & 128) != 0 && (d & 31) < 16)
            m_mem[b][d & 31] = m_stage[b];
         m_load[b] = (d >> 7) & 1;
         m_idx[b]  = d & 31;
      end
   endfunction

   task automatic step(input bit wr, input int a, input int d, input string tag);
      int exp;
      @(negedge clk);
      bus_wr    = wr;
      bus_addr  = a[2:0];
      bus_wdata = d[7:0];
      #1;
      exp = model_rd(a);
      vectors++;
      if (bus_rdata !== exp[7:0]) begin
         miscompares++;
         $display("FAIL %s addr=%0d actual=%02h expected=%02h", tag, a, bus_rdata, exp[7:0]);
      end
      @(posedge clk);
      if (wr) model_wr(a, d);
   endtask

   task automatic rd(input int a, input string tag);
      step(1'b0, a, 0, tag);
   endtask

   task automatic sweep(input string tag);
      for (int a = 0; a < 8; a++) rd(a, tag);
   endtask

   task automatic peek(input int b, input int i, input string tag);
      step(1'b1, 2 * b, i, tag);
      rd(2 * b + 1, tag);
   endtask

   task automatic poke(input int b, input int i, input int v, input string tag);
      step(1'b1, 2 * b + 1, v, tag);
      step(1'b1, 2 * b, i, tag);
      step(1'b1, 2 * b, 128 + i, tag);
      step(1'b1, 2 * b, i, tag);
   endtask

   task automatic readback_all(input string tag);
      for (int b = 0; b < 3; b++)
         for (int i = 0; i < 32; i++) peek(b, i, tag);
   endtask

   initial begin
      for (int b = 0; b < 3; b++) begin
         m_idx[b] = 0; m_load[b] = 0; m_stage[b] = 0;
         for (int i = 0; i < 32; i++) m_mem[b][i] = 0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      sweep("R1 reset windows");
      readback_all("R1 reset registers");

      // R4 staging write leaves internal registers alone
      step(1'b1, 1, 8'hA5, "R4 data write");
      peek(0, 0, "R4 no internal change");
      peek(0, 3, "R4 no internal change");

      // R5 commit on rising load
      poke(0, 3, 8'hA5, "R5 commit");
      peek(0, 3, "R5 readback");
      peek(0, 2, "R5 neighbour untouched");

      // R6 load already high: no second commit, also on fall
      step(1'b1, 0, 128 + 5, "R6 rise to idx5");
      step(1'b1, 1, 8'h5A, "R7 stage while load high");
      rd(1, "R7 data window shows staging");
      step(1'b1, 0, 128 + 6, "R6 load held high");
      step(1'b1, 0, 6, "R6 load falls");
      peek(0, 6, "R6 no commit on hold or fall");
      peek(0, 5, "R6 rise used old staging");

      // R3 reserved control bits
      step(1'b1, 0, 8'hFF, "R3 all ones");
      rd(0, "R3 reserved bits zero");
      step(1'b1, 0, 8'h60, "R3 reserved only");
      rd(0, "R3 reserved bits zero");

      // R8 out-of-range index
      poke(1, 20, 8'h77, "R8 commit beyond depth");
      peek(1, 20, "R8 reads zero");
      peek(1, 4, "R8 no alias");

      // R2 unmapped offsets
      step(1'b1, 6, 8'h81, "R2 write offset 6");
      step(1'b1, 7, 8'h3C, "R2 write offset 7");
      sweep("R2 unmapped ignored");

      // R9 bank independence
      poke(1, 7, 8'h11, "R9 bank1");
      poke(2, 7, 8'h22, "R9 bank2");
      peek(0, 7, "R9 bank0 unaffected");
      peek(1, 7, "R9 bank1 value");
      peek(2, 7, "R9 bank2 value");

      // R5 R7 fill every register with read-modify-write, then read back
      for (int b = 0; b < 3; b++)
         for (int i = 0; i < 16; i++) begin
            peek(b, i, "R7 rmw read");
            poke(b, i, (m_mem[b][i] ^ (b * 53 + i * 7 + 1)) & 255, "R5 rmw write");
         end
      readback_all("R5 R8 full readback");
      sweep("R1 final windows");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog all requirements actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule